// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block picks one of five peripheral interrupt requests for a small 8-bit processor core and gives the vector address that the core jumps to. Each request line sets a pending flag. The core signals an instruction boundary with a strobe. At that strobe the block looks at the pending flags that are enabled. If the global enable bit is set, it takes the one with the lowest vector address. In that same cycle it raises a take pulse, outputs the vector and sends a one-cycle acknowledge to the chosen source.

The block owns the global enable bit. Reset clears it. Taking an interrupt clears it in hardware, and only a return-from-interrupt strobe sets it again. The block does not save or restore the processor status, and it does not handle the program counter. Vector 0 belongs to reset and is never produced for an interrupt. While nothing is taken, the vector output reads 0.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the global enable bit reads 0, every pending flag is clear, and no take or acknowledge is produced.
- R2: Source k (k = 0..4, in the order external request 0, external request 1, port low level, timer overflow, comparator) is served at vector k+1. An interrupt never uses vector 0, and vector_o reads 0 in every cycle without a take.
- R3: When several enabled sources are pending, the one with the lowest index (lowest vector) is taken.
- R4: A source is taken only if its pending flag is set, its enable bit is 1 and the global enable bit is 1, all in a cycle in which boundary_i is 1.
- R5: While the global enable bit is 0, no interrupt is taken, whatever the enable mask holds.
- R6: Hardware clears the global enable bit on the clock edge that ends a take cycle.
- R7: reti_i sets the global enable bit on the next edge. If a take happens in the same cycle, the clear wins.
- R8: The acknowledge is a one-hot pulse in the take cycle, on the bit of the chosen source. It clears only that source's pending flag.
- R9: A pending flag stays set while the source is masked or the global enable bit is 0. The source is taken at a later boundary once it is allowed.
- R10: At most one interrupt is taken per boundary, and none is taken in a cycle without a boundary strobe.
- R11: A request that is present in the cycle its source is acknowledged leaves the flag pending afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req_i | input | 5 | Request lines. A 1 in any cycle sets that source's pending flag |
| irq_en_i | input | 5 | Per-source enable mask |
| boundary_i | input | 1 | Instruction boundary strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| take_o | output | 1 | Take-interrupt pulse |
| vector_o | output | 3 | Vector address of the taken source, 0 otherwise |
| ack_o | output | 5 | One-hot acknowledge to the taken source |
| gie_o | output | 1 | Current global enable bit |

## Verification
The hardest case to reach is a cycle that combines a pending flag with several other events: the flag's own request arriving again, a return strobe, and a boundary, all while the global enable bit is set. The bench sets up this case on purpose. It pulses a request in the exact cycle the same source is acknowledged, and it asserts the return strobe in a cycle that also takes an interrupt. A behavioural model then follows the flags through long random runs. Those runs mix masking, bursts of requests and sparse boundaries, and the model is compared with the outputs on every clock.

// File: rtl/irq_pkg.sv
// Package: shared sizing for the interrupt vector controller.
// Assumes: vector 0 is reserved for reset, interrupts start at vector 1.
package irq_pkg;
    localparam int IRQ_SRC_N = 5;
    localparam int IRQ_VEC_W = $clog2(IRQ_SRC_N + 1);
endpackage

// File: rtl/irq_pending_bank.sv
// Module: one pending flag per source.
// A request sets its flag. An acknowledge clears it, unless the same
// source requests again in that cycle, in which case the set wins.
// Assumes: ack_i is one-hot or zero.
module irq_pending_bank #(
    parameter int N = irq_pkg::IRQ_SRC_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] ack_i,
    output logic [N-1:0] pend_o
);
    logic [N-1:0] pend_q;

    for (genvar g = 0; g < N; g++) begin : g_flag
        // holds the pending state of one source
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend_q[g] <= 1'b0;
            else if (req_i[g])
                pend_q[g] <= 1'b1;
            else if (ack_i[g])
                pend_q[g] <= 1'b0;
        end

        AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            ack_i[g] && !req_i[g] |=> !pend_q[g]); // R8
        AST_REQ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            req_i[g] |=> pend_q[g]); // R11
        AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            pend_q[g] && !ack_i[g] |=> pend_q[g]); // R9
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/irq_prio_encoder.sv
// Module: picks the lowest-index eligible source.
// Outputs a one-hot grant and the vector, which is the index plus one.
// Assumes: it is purely combinational; vector 0 means that no source won.
module irq_prio_encoder #(
    parameter int N     = irq_pkg::IRQ_SRC_N,
    parameter int VEC_W = irq_pkg::IRQ_VEC_W
) (
    input  logic [N-1:0]     elig_i,
    output logic [N-1:0]     grant_o,
    output logic [VEC_W-1:0] vec_o
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;
    for (genvar g = 0; g < N; g++) begin : g_chain
        assign grant_o[g]  = elig_i[g] & ~seen[g];
        assign seen[g + 1] = seen[g] | elig_i[g];
    end

    // turns the one-hot grant into a vector address
    always_comb begin
        vec_o = '0;
        for (int i = 0; i < N; i++)
            if (grant_o[i]) vec_o = vec_o | VEC_W'(i + 1);
    end
endmodule

// File: rtl/irq_gie_ctrl.sv
// Module: global interrupt enable bit.
// The bit is cleared by reset and by a take, and set by a return strobe.
// Assumes: when a take and a return strobe come in the same cycle, the take wins.
module irq_gie_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic take_i,
    input  logic reti_i,
    output logic gie_o
);
    logic gie_q;

    // updates the global enable bit
    always_ff @(posedge clk) begin
        if (!rst_n)
            gie_q <= 1'b0;
        else if (take_i)
            gie_q <= 1'b0;
        else if (reti_i)
            gie_q <= 1'b1;
    end

    AST_TAKE_CLEARS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> !gie_q); // R6
    AST_RETI_SETS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        reti_i && !take_i |=> gie_q); // R7
    AST_GIE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !reti_i && !take_i |=> $stable(gie_q)); // R7

    assign gie_o = gie_q;
endmodule

// File: rtl/irq_vector_ctrl.sv
// Module: top of the prioritized interrupt vector controller.
// At a boundary strobe, with the global enable set, it takes the
// lowest-vector source that is pending and enabled, acknowledges it and
// clears the global enable.
// Assumes: the core pulses boundary_i once per instruction, and reti_i
// once per return from interrupt.
module irq_vector_ctrl #(
    parameter int N     = irq_pkg::IRQ_SRC_N,
    parameter int VEC_W = irq_pkg::IRQ_VEC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     irq_req_i,
    input  logic [N-1:0]     irq_en_i,
    input  logic             boundary_i,
    input  logic             reti_i,
    output logic             take_o,
    output logic [VEC_W-1:0] vector_o,
    output logic [N-1:0]     ack_o,
    output logic             gie_o
);
    logic [N-1:0]     pend;
    logic [N-1:0]     elig;
    logic [N-1:0]     grant;
    logic [VEC_W-1:0] vec;
    logic             gie;
    logic             fire;

    irq_pending_bank #(.N(N)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (irq_req_i),
        .ack_i  (ack_o),
        .pend_o (pend)
    );

    // a source is eligible only when it is pending and enabled
    assign elig = pend & irq_en_i;

    irq_prio_encoder #(.N(N), .VEC_W(VEC_W)) u_prio (
        .elig_i  (elig),
        .grant_o (grant),
        .vec_o   (vec)
    );

    // take decision: boundary, global enable and at least one eligible source
    assign fire     = boundary_i & gie & (|elig);
    assign take_o   = fire;
    assign ack_o    = fire ? grant : '0;
    assign vector_o = fire ? vec : '0;

    irq_gie_ctrl u_gie (
        .clk    (clk),
        .rst_n  (rst_n),
        .take_i (fire),
        .reti_i (reti_i),
        .gie_o  (gie)
    );

    assign gie_o = gie;

    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $countones(ack_o) == 1); // R8
    AST_NO_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> ack_o == '0 && vector_o == '0); // R2
    AST_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> gie_o && boundary_i); // R5
    AST_ACK_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (ack_o & irq_en_i & pend) == ack_o); // R4
    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> ((ack_o - 1'b1) & elig) == '0); // R3
    AST_VEC_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> vector_o != '0); // R2
    AST_ONE_PER_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o); // R10
endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] irq_req_i = '0;
    logic [N-1:0] irq_en_i = '0;
    logic         boundary_i = 1'b0;
    logic         reti_i = 1'b0;
    logic         take_o;
    logic [2:0]   vector_o;
    logic [N-1:0] ack_o;
    logic         gie_o;

    int total = 0;
    int bad = 0;
    string tag = "R1";

    // behavioural model state
    bit [N-1:0] m_pend;
    bit         m_gie;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_vector_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req_i), .irq_en_i(irq_en_i),
        .boundary_i(boundary_i), .reti_i(reti_i), .take_o(take_o),
        .vector_o(vector_o), .ack_o(ack_o), .gie_o(gie_o)
    );

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++; bad++;
        $display("FAIL watchdog: run did not finish");
        summary();
    end

    // one cycle: drive inputs, compare against the model, then advance the model
    task automatic step(input logic [N-1:0] r, input logic [N-1:0] e,
                        input logic b, input logic t);
        bit [N-1:0] elig;
        bit         x_take;
        int         x_vec;
        bit [N-1:0] x_ack;
        @(negedge clk);
        irq_req_i = r; irq_en_i = e; boundary_i = b; reti_i = t;
        #1;
        elig = m_pend & e;
        x_take = b && m_gie && (elig != 0);
        x_vec = 0; x_ack = '0;
        if (x_take) begin
            for (int i = N - 1; i >= 0; i--)
                if (elig[i]) begin x_vec = i + 1; x_ack = N'(1) << i; end
        end
        total++;
        if (take_o !== x_take || vector_o !== 3'(x_vec) || ack_o !== x_ack || gie_o !== m_gie) begin
            bad++;
            $display("FAIL %s: take=%b vec=%0d ack=%b gie=%b expected take=%b vec=%0d ack=%b gie=%b",
                     tag, take_o, vector_o, ack_o, gie_o, x_take, x_vec, x_ack, m_gie);
        end
        @(posedge clk);
        m_pend = (m_pend & ~x_ack) | r;
        if (x_take) m_gie = 1'b0;
        else if (t) m_gie = 1'b1;
    endtask

    initial begin
        m_pend = '0; m_gie = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state, with a boundary strobe and everything enabled
        tag = "R1";
        step('0, '1, 1'b1, 1'b0);
        // R5 / R9: request while the global enable is clear stays pending
        tag = "R5";
        step(5'b00010, '1, 1'b0, 1'b0);
        step('0, '1, 1'b1, 1'b0);
        step('0, '1, 1'b1, 1'b0);
        // R7: return strobe sets the enable; R9: the held request is then taken at vector 2
        tag = "R7";
        step('0, '1, 1'b0, 1'b1);
        tag = "R9";
        step('0, '1, 1'b1, 1'b0);
        // R6: the enable is cleared after a take, so no further take
        tag = "R6";
        step(5'b00001, '1, 1'b1, 1'b0);
        step('0, '1, 1'b1, 1'b0);
        // R3 / R2: all sources pending, served in order at vectors 1..5
        tag = "R3";
        step(5'b11110, '1, 1'b0, 1'b1);
        for (int k = 0; k < N; k++) begin
            tag = "R2";
            step('0, '1, 1'b1, 1'b0);
            step('0, '1, 1'b0, 1'b1);
        end
        // R4: a masked source is skipped in favour of an enabled one
        tag = "R4";
        step(5'b01001, 5'b11110, 1'b1, 1'b0);
        step('0, 5'b11110, 1'b1, 1'b0);
        step('0, 5'b11110, 1'b0, 1'b1);
        // R9: source 0 is still pending and is taken once it is unmasked
        tag = "R9";
        step('0, 5'b11110, 1'b1, 1'b0);
        step('0, 5'b11111, 1'b1, 1'b0);
        // R10: no take without a boundary, even when everything is allowed
        tag = "R10";
        step(5'b00100, '1, 1'b0, 1'b1);
        step('0, '1, 1'b0, 1'b0);
        step('0, '1, 1'b0, 1'b0);
        step('0, '1, 1'b1, 1'b0);
        // R11: a request in its own acknowledge cycle stays pending
        tag = "R11";
        step(5'b10000, '1, 1'b0, 1'b1);
        step(5'b10000, '1, 1'b1, 1'b0);
        step('0, '1, 1'b0, 1'b1);
        step('0, '1, 1'b1, 1'b0);
        // R7: a take in the same cycle as a return strobe leaves the enable clear
        tag = "R7";
        step(5'b01000, '1, 1'b0, 1'b1);
        step('0, '1, 1'b1, 1'b1);
        step('0, '1, 1'b1, 1'b0);
        // R8: random traffic; the acknowledge and pending clear are tracked by the model
        tag = "R8";
        for (int n = 0; n < 3000; n++) begin
            logic [N-1:0] rr, ee;
            rr = (($urandom % 4) == 0) ? N'($urandom) : '0;
            ee = N'($urandom) | N'($urandom);
            step(rr, ee, 1'($urandom % 3 == 0), 1'($urandom % 5 == 0));
        end
        // R1: a mid-run reset returns the block to its idle state
        tag = "R1";
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk);
        m_pend = '0; m_gie = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        step('0, '1, 1'b1, 1'b0);
        summary();
    end
endmodule